// File: doc/BRIEF.md
# Set/Clear Clock Gate Controller

This block holds one enable bit for each clock domain in a bank of up to 32 and drives those bits out as `gate_en`. They can feed clock-gating cells or act as per-domain clock enables. Software controls the bank through a three-word register window. One word switches gates on, one switches them off, and one reports their present state. Because a write only acts on the bits written as 1, software can switch one gate without first reading the others back.

The register port has a write channel and a read channel, and both can act in the same cycle. A write takes effect at the clock edge that samples it. A read returns its word on `rd_data` one cycle after `rd_valid`. `rd_data` then holds that value until the next read.

Top module: `clkgate_setclr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gate_en` takes the value of the parameter `RESET_VAL` (default all ones) and `rd_data` becomes zero.
- R2: A write to byte offset 0x4 turns on each gate n whose data bit n is 1, at the edge that samples the write. Gates whose data bit is 0 keep their state.
- R3: A write to byte offset 0x8 turns off each gate n whose data bit n is 1, at the edge that samples the write. Gates whose data bit is 0 keep their state.
- R4: A read of offset 0x0 puts the gate states on `rd_data` one cycle after `rd_valid`, with gate n in bit n and zeros in the bits above `NUM_GATES-1`.
- R5: A write to offset 0x0, or to any address other than exactly 0x4 or 0x8 (misaligned addresses and 0xC upward included), leaves every gate unchanged.
- R6: A read of offset 0x4, offset 0x8, or any address other than exactly 0x0 returns zero.
- R7: A read and a write issued in the same cycle are both served. The read returns the gate states from before that write, and the write takes effect at that same edge.
- R8: `rd_data` holds its value in every cycle where `rd_valid` is low.
- R9: `gate_en` does not change in a cycle where `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request, valid for one cycle |
| wr_addr | input | ADDR_W | Write byte address within the window |
| wr_data | input | 32 | Write data, one bit per gate |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address within the window |
| rd_data | output | 32 | Read data, valid the cycle after `rd_valid` and held until the next read |
| gate_en | output | NUM_GATES | Enable bit for each gate |

## Verification
A status read and a set or clear write can fall in the same cycle, because the read and write channels are separate. The bench provokes this with directed cases and with many random cycles in which both channels are active. Each time, it expects `rd_data` to show the gate states from before the write and `gate_en` to show them after it. A reference model computes both values at once, and the bench compares them with the design every cycle.

// File: rtl/gc_pkg.sv
// Package: shared constants for the set/clear clock gate controller.
// Assumes byte addressing, with one 32-bit word per register.
package gc_pkg;
    localparam int DATA_W     = 32;
    localparam int OFF_STATUS = 'h0;
    localparam int OFF_SET    = 'h4;
    localparam int OFF_CLEAR  = 'h8;
endpackage

// File: rtl/gc_decode.sv
// Module: gc_decode
// Turns a register-port request into per-bit set and clear vectors and a
// status-read select. Purely combinational. Assumes each register is hit
// only by its exact byte offset; every other address selects nothing.
module gc_decode #(
    parameter int ADDR_W    = 4,
    parameter int NUM_GATES = 32
) (
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [gc_pkg::DATA_W-1:0] wr_data,
    input  logic                      rd_valid,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [NUM_GATES-1:0]      set_vec,
    output logic [NUM_GATES-1:0]      clr_vec,
    output logic                      rd_status
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(gc_pkg::OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(gc_pkg::OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(gc_pkg::OFF_CLEAR);

    logic hit_set;
    logic hit_clr;

    // Purpose: match the write address against the set and clear offsets.
    always_comb begin
        hit_set = wr_valid && (wr_addr == A_SET);
        hit_clr = wr_valid && (wr_addr == A_CLEAR);
    end

    // Purpose: build the per-bit action vectors from the write data.
    always_comb begin
        set_vec = hit_set ? wr_data[NUM_GATES-1:0] : '0;
        clr_vec = hit_clr ? wr_data[NUM_GATES-1:0] : '0;
    end

    // Purpose: select the status word for a read of offset zero.
    always_comb begin
        rd_status = rd_valid && (rd_addr == A_STATUS);
    end
endmodule

// File: rtl/gc_gate_bank.sv
// Module: gc_gate_bank
// Holds one enable flop per gate. Clear beats set on the same bit.
// Assumes synchronous active-low reset and takes reset values from RESET_VAL.
module gc_gate_bank #(
    parameter int                   NUM_GATES = 32,
    parameter logic [NUM_GATES-1:0] RESET_VAL = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GATES-1:0] set_vec,
    input  logic [NUM_GATES-1:0] clr_vec,
    output logic [NUM_GATES-1:0] gate_q
);
    for (genvar i = 0; i < NUM_GATES; i++) begin : g_bit
        // Purpose: update one gate from its set and clear strobes.
        always_ff @(posedge clk) begin
            if (!rst_n)          gate_q[i] <= RESET_VAL[i];
            else if (clr_vec[i]) gate_q[i] <= 1'b0;
            else if (set_vec[i]) gate_q[i] <= 1'b1;
        end

        AST_CLR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |=> !gate_q[i]); // R3
        AST_SET_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && !clr_vec[i]) |=> gate_q[i]); // R2
        AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[i] && !clr_vec[i]) |=> $stable(gate_q[i])); // R5
    end
endmodule

// File: rtl/gc_read_port.sv
// Module: gc_read_port
// Registers the read word. It loads the status or zero on a read and holds otherwise.
// Assumes the caller has already decoded whether the read targets status.
module gc_read_port #(
    parameter int NUM_GATES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_valid,
    input  logic                      rd_status,
    input  logic [NUM_GATES-1:0]      gate_q,
    output logic [gc_pkg::DATA_W-1:0] rd_data
);
    // Purpose: capture the read word. It holds its value when no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_valid)  rd_data <= rd_status ? gc_pkg::DATA_W'(gate_q) : '0;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(rd_data)); // R8
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_status) |=> (rd_data == '0)); // R6
    AST_RD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (rd_data == gc_pkg::DATA_W'($past(gate_q)))); // R7
endmodule

// File: rtl/clkgate_setclr.sv
// Module: clkgate_setclr
// Bank of clock enables behind a status / write-one-to-set / write-one-to-clear
// register window. Assumes NUM_GATES <= 32 and ADDR_W >= 4.
module clkgate_setclr #(
    parameter int                   ADDR_W    = 4,
    parameter int                   NUM_GATES = 32,
    parameter logic [NUM_GATES-1:0] RESET_VAL = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [gc_pkg::DATA_W-1:0] wr_data,
    input  logic                      rd_valid,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [gc_pkg::DATA_W-1:0] rd_data,
    output logic [NUM_GATES-1:0]      gate_en
);
    logic [NUM_GATES-1:0] set_vec;
    logic [NUM_GATES-1:0] clr_vec;
    logic                 rd_status;

    gc_decode #(.ADDR_W(ADDR_W), .NUM_GATES(NUM_GATES)) u_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rd_status(rd_status)
    );

    gc_gate_bank #(.NUM_GATES(NUM_GATES), .RESET_VAL(RESET_VAL)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .gate_q (gate_en)
    );

    gc_read_port #(.NUM_GATES(NUM_GATES)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_status(rd_status),
        .gate_q   (gate_en),
        .rd_data  (rd_data)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(gate_en)); // R9
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(gc_pkg::OFF_STATUS)) |=> $stable(gate_en)); // R5
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(gc_pkg::OFF_SET))
        |=> ((gate_en & $past(wr_data[NUM_GATES-1:0])) == $past(wr_data[NUM_GATES-1:0]))); // R2
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(gc_pkg::OFF_CLEAR))
        |=> ((gate_en & $past(wr_data[NUM_GATES-1:0])) == '0)); // R3
    AST_RESET_VAL: assert property (@(posedge clk)
        !rst_n |=> (gate_en == RESET_VAL && rd_data == '0)); // R1
endmodule

// File: tb/clkgate_setclr_tb_top.sv
module clkgate_setclr_tb_top;
    localparam int AW = 4;
    localparam int NG = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NG-1:0] gate_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NG-1:0] m_gate;
    logic [31:0]   m_rd;

    always #2 clk = ~clk;

    clkgate_setclr #(.ADDR_W(AW), .NUM_GATES(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .gate_en(gate_en)
    );

    function automatic logic [NG-1:0] next_gate(logic [NG-1:0] cur, logic wv,
                                                logic [AW-1:0] wa, logic [31:0] wd);
        if (!wv) return cur;
        if (wa == 4'h4) return cur | wd[NG-1:0];
        if (wa == 4'h8) return cur & ~wd[NG-1:0];
        return cur;
    endfunction

    function automatic logic [31:0] next_rd(logic [31:0] cur, logic [NG-1:0] g,
                                            logic rv, logic [AW-1:0] ra);
        if (!rv) return cur;
        return (ra == 4'h0) ? 32'(g) : 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample 1 ns after the posedge.
    task automatic cyc(logic wv, logic [AW-1:0] wa, logic [31:0] wd,
                       logic rv, logic [AW-1:0] ra, string wtag, string rtag);
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_addr = ra;
        m_rd   = next_rd(m_rd, m_gate, rv, ra);
        m_gate = next_gate(m_gate, wv, wa, wd);
        @(posedge clk);
        #1;
        check(wtag, 32'(gate_en), 32'(m_gate));
        check(rtag, rd_data, m_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1C));
        repeat (3) @(posedge clk);
        #1;
        check("R1 gate reset", 32'(gate_en), 32'hFFFF_FFFF);
        check("R1 rd reset", rd_data, 32'h0);
        m_gate = '1; m_rd = '0;
        @(negedge clk); rst_n = 1'b1;

        cyc(1, 4'h8, 32'h0000_00F0, 0, 0, "R3 clear", "R8 hold");
        cyc(1, 4'h8, 32'h0, 0, 0, "R3 zero no-op", "R8 hold");
        cyc(1, 4'h4, 32'h0000_0010, 0, 0, "R2 set", "R8 hold");
        cyc(1, 4'h4, 32'h0, 0, 0, "R2 zero no-op", "R8 hold");
        cyc(1, 4'h0, 32'h0, 1, 4'h0, "R5 status write", "R4 status read");
        cyc(1, 4'hC, 32'h0, 1, 4'h4, "R5 unmapped write", "R6 read set reg");
        cyc(1, 4'h9, 32'hFFFF_FFFF, 1, 4'h0, "R5 misaligned write", "R4 status read");
        cyc(0, 4'h8, 32'hFFFF_FFFF, 1, 4'h8, "R9 idle write", "R6 read clear reg");
        cyc(1, 4'h8, 32'hA5A5_0000, 1, 4'h0, "R7 clear with read", "R7 read before clear");
        cyc(0, 4'h0, 32'h0, 1, 4'h0, "R9 idle", "R4 status after clear");
        cyc(1, 4'h4, 32'h0005_0000, 1, 4'h0, "R7 set with read", "R7 read before set");
        cyc(0, 4'h0, 32'h0, 1, 4'hD, "R9 idle", "R6 read unmapped");
        cyc(0, 4'h0, 32'h0, 0, 4'h0, "R9 idle", "R8 hold zero");

        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] wa;
            logic [AW-1:0] ra;
            wa = ($urandom % 4 == 0) ? AW'($urandom) : AW'(($urandom % 3) * 4);
            ra = ($urandom % 4 == 0) ? AW'($urandom) : AW'(($urandom % 3) * 4);
            cyc(1'($urandom), wa, $urandom, 1'($urandom), ra,
                "R2/R3/R5/R9 random write", "R4/R6/R7/R8 random read");
        end

        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 re-reset gate", 32'(gate_en), 32'hFFFF_FFFF);
        check("R1 re-reset rd", rd_data, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule